// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block gathers six interrupt request pulses for a small 8-bit microcontroller core and turns them into one vectored request. Each source has a sticky flag and a mask bit. The core reads and writes the two registers through a simple one-cycle register port. A global enable bit is set by an enable strobe or a return-from-interrupt strobe, and it is cleared by a disable strobe. When an unmasked flag is pending and the global enable is set, the block asks for an interrupt. At the next instruction fetch the block forces the fetch address to the vector and drops the global enable, so that a second entry cannot nest inside the first.

Most flags record their event even when the event is masked, and a status read shows only the unmasked part. The input-change flag is the exception: it records an event only while its mask bit is set. Flags leave the set state only through software writes. A flag that is still set after return therefore raises the request again. While the core sleeps, any pending unmasked flag raises a wake signal, whatever the state of the global enable. With the global enable clear, the core wakes and continues in line without taking the vector.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After synchronous reset, all flags, all mask bits and the global enable are 0, and irq_req, vec_take and wake are low.
- R2: An event pulse on source bit 0 (timer overflow), 2 (external pin), 3 (conversion done), 4 (period match) or 5 (comparator change) sets that flag on the next edge, whatever the mask bit and the global enable.
- R3: An event on source bit 1 (input change) sets its flag only when mask bit 1 is 1 in the same cycle. Otherwise the event is dropped.
- R4: With reg_sel=0 the read data is the flags ANDed with the mask, in bits 5:0. With reg_sel=1 it is the mask. Bits 7:6 read 0.
- R5: A write with reg_sel=0 clears each flag whose data bit is 0 and leaves the flags whose data bit is 1. An event on the same flag in the same cycle wins, so the flag ends set.
- R6: irq_req is high exactly when the global enable is 1 and some flag is set together with its mask bit.
- R7: ei_stb or reti_stb sets the global enable, and di_stb clears it. When di_stb and either set strobe arrive in the same cycle, di_stb wins.
- R8: When fetch_en is high while irq_req is high, vec_take is high and vec_addr reads 0x008 in that cycle. The global enable is then 0 from the next cycle. Only a software clear removes the flag, so after reti_stb the request is raised again.
- R9: While sleep_i is high, wake is high whenever some flag is set together with its mask bit, even with the global enable clear. In that case vec_take stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 6 | One-cycle event pulses, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status/flags register, 1 selects the mask |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| fetch_en | input | 1 | The core is at an instruction-fetch boundary |
| sleep_i | input | 1 | The core is in sleep mode |
| irq_req | output | 1 | Interrupt request |
| vec_take | output | 1 | The vector replaces the next fetch address |
| vec_addr | output | 12 | Vector address while vec_take is high, 0 otherwise |
| gie_o | output | 1 | Current global enable |
| wake | output | 1 | Wake-up request for sleep mode |

## Verification
The bench builds the block with its default parameters: a 12-bit fetch address, vector 0x008 and an 8-bit read bus. With these values the zero-filled upper read bits and the exact vector value can be checked at the ports. The scenarios cover the following:
- masked events latching behind a status read that shows zero;
- the gated input-change flag;
- an event and a software clear colliding on one flag;
- the disable strobe beating an enable strobe;
- the enable being dropped on vector entry, then re-entry after return while the flag is still set;
- a sleep wake taken with the global enable clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC = 6;

    // Bit positions of the request sources within the flag and mask words
    typedef enum logic [2:0] {
        SRC_TMR_OVF  = 3'd0,
        SRC_IN_CHG   = 3'd1,
        SRC_EXT_PIN  = 3'd2,
        SRC_ADC_DONE = 3'd3,
        SRC_PRD_HIT  = 3'd4,
        SRC_CMP_CHG  = 3'd5
    } src_e;

    // Sources whose flag may only latch while their mask bit is set
    localparam logic [NSRC-1:0] GATED_SRC = NSRC'(1) << SRC_IN_CHG;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic            wr;
        reg_sel_e        sel;
        logic [NSRC-1:0] data;
    } reg_req_t;

    typedef struct packed {
        logic ei;
        logic di;
        logic reti;
    } gie_ctl_t;

    function automatic logic any_pending(input logic [NSRC-1:0] f,
                                         input logic [NSRC-1:0] m);
        return |(f & m);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int N = NSRC,
    parameter logic [N-1:0] GATED = GATED_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] keep_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic set_now;
        logic hold;

        if (GATED[i]) begin : g_gated
            assign set_now = evt[i] & mask[i];
        end else begin : g_free
            assign set_now = evt[i];
        end

        assign hold = clr_en ? (flags[i] & keep_bits[i]) : flags[i];

        always_ff @(posedge clk) begin
            if (rst) flags[i] <= 1'b0;
            else     flags[i] <= set_now | hold;
        end

        if (GATED[i]) begin : g_chk_gated
            // R3: an input-change event behind a cleared mask bit leaves the flag clear
            a_r3_gated_drop: assert property (@(posedge clk) disable iff (rst)
                (evt[i] && !mask[i] && !flags[i]) |=> !flags[i]);
        end else begin : g_chk_free
            // R2 / R5: an event always leaves its flag set, even against a clear
            a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> flags[i]);
        end
    end

    // R5: with no event and no clear, a flag never changes
    a_r5_flags_stable: assert property (@(posedge clk) disable iff (rst)
        (!clr_en && evt == '0) |=> $stable(flags));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst)        mask <= '0;
        else if (wr_en) mask <= wdata;
    end

    // R4: without a mask write the mask holds
    a_r4_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask));

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pkg::*;
#(
    parameter int N = NSRC,
    parameter int PC_W = 12,
    parameter logic [PC_W-1:0] VEC = PC_W'(8)
) (
    input  logic            clk,
    input  logic            rst,
    input  gie_ctl_t        ctl,
    input  logic [N-1:0]    flags,
    input  logic [N-1:0]    mask,
    input  logic            fetch_en,
    input  logic            sleep_i,
    output logic            gie,
    output logic            irq_req,
    output logic            vec_take,
    output logic [PC_W-1:0] vec_addr,
    output logic            wake
);

    logic pend;

    assign pend     = any_pending(flags, mask);
    assign irq_req  = gie & pend;
    assign vec_take = fetch_en & irq_req;
    assign vec_addr = vec_take ? VEC : '0;
    assign wake     = sleep_i & pend;

    always_ff @(posedge clk) begin
        if (rst)                     gie <= 1'b0;
        else if (vec_take)           gie <= 1'b0;
        else if (ctl.di)             gie <= 1'b0;
        else if (ctl.ei || ctl.reti) gie <= 1'b1;
    end

    // R8: entering the vector drops the global enable
    a_r8_take_clears: assert property (@(posedge clk) disable iff (rst)
        vec_take |=> !gie);

    // R7: the disable strobe wins over any set strobe
    a_r7_di_wins: assert property (@(posedge clk) disable iff (rst)
        ctl.di |=> !gie);

    // R7: a set strobe without disable or vector entry raises the enable
    a_r7_set: assert property (@(posedge clk) disable iff (rst)
        ((ctl.ei || ctl.reti) && !ctl.di && !vec_take) |=> gie);

    // R9: the vector is never taken while the enable is clear
    a_r9_no_take_gie_off: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !vec_take);

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int PC_W = 12,
    parameter int VEC_ADDR = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              reti_stb,
    input  logic              fetch_en,
    input  logic              sleep_i,
    output logic              irq_req,
    output logic              vec_take,
    output logic [PC_W-1:0]   vec_addr,
    output logic              gie_o,
    output logic              wake
);

    localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

    reg_req_t        req;
    gie_ctl_t        ctl;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] rd_word;

    assign req.wr   = reg_wr;
    assign req.sel  = reg_sel_e'(reg_sel);
    assign req.data = reg_wdata;

    assign ctl.ei   = ei_stb;
    assign ctl.di   = di_stb;
    assign ctl.reti = reti_stb;

    irq_mask_reg #(.N(NSRC)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr_en (req.wr && req.sel == SEL_MASK),
        .wdata (req.data),
        .mask  (mask)
    );

    irq_flag_bank #(.N(NSRC), .GATED(GATED_SRC)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_i),
        .clr_en    (req.wr && req.sel == SEL_STATUS),
        .keep_bits (req.data),
        .mask      (mask),
        .flags     (flags)
    );

    irq_gate #(.N(NSRC), .PC_W(PC_W), .VEC(VEC)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .flags    (flags),
        .mask     (mask),
        .fetch_en (fetch_en),
        .sleep_i  (sleep_i),
        .gie      (gie_o),
        .irq_req  (irq_req),
        .vec_take (vec_take),
        .vec_addr (vec_addr),
        .wake     (wake)
    );

    always_comb begin
        case (req.sel)
            SEL_MASK: rd_word = mask;
            default:  rd_word = flags & mask;
        endcase
    end

    assign reg_rdata = DATA_W'(rd_word);

    // R6: a request implies the enable is set
    a_r6_req_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> gie_o);

    // R8: a flag that stays set re-requests once return restores the enable
    a_r8_rearm: assert property (@(posedge clk) disable iff (rst)
        (reti_stb && !di_stb && !vec_take && (flags & mask) != '0 && !reg_wr
         && evt_i == '0) |=> irq_req);

endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  evt_i = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [5:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ei_stb = 1'b0, di_stb = 1'b0, reti_stb = 1'b0;
    logic        fetch_en = 1'b0, sleep_i = 1'b0;
    logic        irq_req, vec_take, gie_o, wake;
    logic [11:0] vec_addr;

    always #5 clk = ~clk;

    irq_flag_ctrl dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ei_stb(ei_stb),
        .di_stb(di_stb), .reti_stb(reti_stb), .fetch_en(fetch_en),
        .sleep_i(sleep_i), .irq_req(irq_req), .vec_take(vec_take),
        .vec_addr(vec_addr), .gie_o(gie_o), .wake(wake)
    );

    typedef struct {
        logic [7:0]  rd;
        logic        req;
        logic        take;
        logic [11:0] va;
        logic        gie;
        logic        wk;
        string       tag;
    } exp_t;

    exp_t q[$];
    event mon_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Reference state, computed only from the requirements
    logic [5:0] mf = '0, mm = '0;
    logic       mg = 1'b0;

    always begin
        @(mon_ev);
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (reg_rdata !== e.rd || irq_req !== e.req || vec_take !== e.take ||
                vec_addr !== e.va || gie_o !== e.gie || wake !== e.wk) begin
                n_fail++;
                $display("FAIL %s: got rd=%h req=%b take=%b va=%h gie=%b wake=%b, expected rd=%h req=%b take=%b va=%h gie=%b wake=%b",
                         e.tag, reg_rdata, irq_req, vec_take, vec_addr, gie_o, wake,
                         e.rd, e.req, e.take, e.va, e.gie, e.wk);
            end
        end
    end

    task automatic step(input logic [5:0] ev, input logic wr, input logic sel,
                        input logic [5:0] wd, input logic ei, input logic di,
                        input logic rt, input logic fe, input logic sl,
                        input string tag);
        exp_t e;
        logic pend;
        logic [5:0] nf;
        @(negedge clk);
        evt_i = ev; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        ei_stb = ei; di_stb = di; reti_stb = rt; fetch_en = fe; sleep_i = sl;
        #1;
        pend   = |(mf & mm);
        e.rd   = sel ? {2'b00, mm} : {2'b00, mf & mm};
        e.req  = mg & pend;
        e.take = fe & e.req;
        e.va   = e.take ? 12'h008 : 12'h000;
        e.gie  = mg;
        e.wk   = sl & pend;
        e.tag  = tag;
        q.push_back(e);
        ->mon_ev;
        // next state at the coming edge
        nf = (wr && !sel) ? (mf & wd) : mf;
        nf = nf | (ev & 6'b111101) | (ev & mm & 6'b000010);
        if (wr && sel) mm = wd;
        mf = nf;
        if (e.take)      mg = 1'b0;
        else if (di)     mg = 1'b0;
        else if (ei|rt)  mg = 1'b1;
    endtask

    task automatic idle(input string tag);
        step(6'h00, 0, 0, 6'h00, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rd(input logic sel, input string tag);
        step(6'h00, 0, sel, 6'h00, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        idle("R1");
        rd(1, "R1");

        // R2: masked events still latch; status reads masked view as zero
        step(6'b111101, 0, 0, 6'h00, 0, 0, 0, 0, 0, "R2");
        rd(0, "R4");
        // unmask everything except input change: status exposes latched flags
        step(6'h00, 1, 1, 6'b111101, 0, 0, 0, 0, 0, "R2");
        rd(0, "R2");
        rd(1, "R4");

        // R3: input-change event with its mask bit clear is dropped
        step(6'b000010, 0, 0, 6'h00, 0, 0, 0, 0, 0, "R3");
        step(6'h00, 1, 1, 6'b111111, 0, 0, 0, 0, 0, "R3");
        rd(0, "R3");
        step(6'b000010, 0, 0, 6'h00, 0, 0, 0, 0, 0, "R3");
        rd(0, "R3");

        // R5: software clear of all, with a collision on bit 3
        step(6'b001000, 1, 0, 6'b000000, 0, 0, 0, 0, 0, "R5");
        rd(0, "R5");
        step(6'h00, 1, 0, 6'b000000, 0, 0, 0, 0, 0, "R5");
        rd(0, "R5");

        // R6/R7: enable with nothing pending gives no request
        step(6'h00, 0, 0, 6'h00, 1, 0, 0, 0, 0, "R7");
        idle("R6");
        step(6'b000100, 0, 0, 6'h00, 0, 0, 0, 0, 0, "R6");
        idle("R6");
        // R8: take the vector, enable drops
        step(6'h00, 0, 0, 6'h00, 0, 0, 0, 1, 0, "R8");
        step(6'h00, 0, 0, 6'h00, 0, 0, 0, 1, 0, "R8");
        // R8: return without clearing re-raises the request
        step(6'h00, 0, 0, 6'h00, 0, 0, 1, 0, 0, "R8");
        step(6'h00, 0, 0, 6'h00, 0, 0, 0, 1, 0, "R8");
        idle("R8");
        // R7: disable beats enable and return
        step(6'h00, 0, 0, 6'h00, 1, 1, 1, 0, 0, "R7");
        idle("R7");
        step(6'h00, 0, 0, 6'h00, 0, 0, 1, 0, 0, "R7");
        idle("R7");
        step(6'h00, 0, 0, 6'h00, 0, 1, 0, 0, 0, "R7");
        idle("R7");

        // R9: sleeping with enable clear: wake, no vector
        step(6'h00, 0, 0, 6'h00, 0, 0, 0, 1, 1, "R9");
        step(6'h00, 1, 0, 6'h00, 0, 0, 0, 0, 1, "R9");
        step(6'h00, 0, 0, 6'h00, 0, 0, 0, 1, 1, "R9");
        // mask cleared: a latched flag no longer wakes
        step(6'b100000, 1, 1, 6'h00, 0, 0, 0, 0, 1, "R9");
        step(6'h00, 0, 0, 6'h00, 0, 0, 0, 0, 1, "R9");
        rd(0, "R4");

        @(negedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule